// File: doc/BRIEF.md
# Keyed Debug-Authorization Registers

This block keeps two small authorization words that decide which debug paths a chip exposes. The first word holds the enables for several debug access ports and one master debug-disable bit. The second word holds the processor's invasive and non-invasive debug enables. Software never writes either word directly. Each word has a write-only set register and a write-only clear register. A write changes the word only when the top byte of the data carries the 8-bit key that belongs to that set or clear register.

Boot code programs the words. It then raises a lock request, and from then on the words are frozen until the next reset. The current values drive the block's outputs all the time and can be read back at their status offsets. Read data is combinational on the address, and writes take effect at the clock edge that samples them.

Top module: `dbg_auth_regs`

## Requirements
- R1: After reset the port word reads 0x13 (bits 0, 1 and 4 set), the processor word reads 0 and the lock is released.
- R2: A write to offset 0x204 whose data bits 31:24 equal 0xA5 sets every port-word bit whose data bit is 1. Bits 0, 2, 4, 5 and 6 are the writable bits. All other bits keep their value, and data bits 23:7 are ignored.
- R3: A write to offset 0x208 whose data bits 31:24 equal 0x22 clears every writable port-word bit whose data bit is 1.
- R4: A write to offset 0x214 whose data bits 31:24 equal 0x39 sets processor-word bits 0 (invasive) and 1 (non-invasive) where the data bit is 1.
- R5: A write to offset 0x218 whose data bits 31:24 equal 0x7D clears processor-word bits where the data bit is 1.
- R6: A write with any other key is ignored entirely, including the key of a different register. A write to an unmapped offset is also ignored.
- R7: Reserved port-word bits 1 and 3 stay at 1 and 0 whatever is set or cleared.
- R8: When lock_req is sampled high at an edge, the write sampled at that same edge is blocked. Every later set or clear write is also blocked until reset.
- R9: Reads at 0x200 return the port word and reads at 0x210 return the processor word, both zero-extended. The set and clear offsets and unmapped offsets read as 0.
- R10: The port_auth and cpu_auth outputs show the stored words and change at the clock edge that accepts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Register offset for both reads and writes |
| bus_wdata | input | 32 | Write data; the key is in bits 31:24 |
| lock_req | input | 1 | Boot-complete request that locks further changes |
| bus_rdata | output | 32 | Read data for bus_addr |
| port_auth | output | 7 | Access-port enables and the debug-disable bit |
| cpu_auth | output | 2 | Processor invasive (bit 0) and non-invasive (bit 1) enables |

## Verification
The assertions assume that each bus_wr pulse targets one offset only, so a set and a clear never reach the same word in one cycle. They also assume lock_req is held low while reset is asserted. The bench drives each write for one cycle between falling edges and keeps lock_req low around every reset. After each write it samples the outputs and the read-back on the following falling edge, so every write fits these assumptions.

// File: rtl/dbg_auth_pkg.sv
// Shared constants for the keyed debug-authorization registers.
// Assumes a 12-bit offset space and 8-bit keys held in the top data byte.
package dbg_auth_pkg;
    localparam int KEY_W  = 8;
    localparam int PORT_W = 7;
    localparam int CPU_W  = 2;

    // Status offsets
    localparam int OFF_PORT_STAT = 'h200;
    localparam int OFF_CPU_STAT  = 'h210;

    // Writer table order: port set, port clear, cpu set, cpu clear
    localparam int NUM_WRITERS = 4;
    localparam int WR_PORT_SET = 0;
    localparam int WR_PORT_CLR = 1;
    localparam int WR_CPU_SET  = 2;
    localparam int WR_CPU_CLR  = 3;

    localparam int WR_OFFSET [NUM_WRITERS] = '{'h204, 'h208, 'h214, 'h218};
    localparam logic [KEY_W-1:0] WR_KEY [NUM_WRITERS] = '{8'hA5, 8'h22, 8'h39, 8'h7D};

    // Reset values and writable masks
    localparam logic [PORT_W-1:0] PORT_RST  = 7'h13;
    localparam logic [PORT_W-1:0] PORT_MASK = 7'h75;
    localparam logic [CPU_W-1:0]  CPU_RST   = 2'b00;
    localparam logic [CPU_W-1:0]  CPU_MASK  = 2'b11;
endpackage

// File: rtl/auth_lock.sv
// Sticky lock for the authorization words.
// Assumes lock_req is a synchronous level; it stays set until reset.
module auth_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_req,
    output logic wr_allow
);
    logic locked_q;

    // Capture the lock request and hold it until reset
    always_ff @(posedge clk) begin
        if (!rst_n) locked_q <= 1'b0;
        else        locked_q <= locked_q | lock_req;
    end

    // A request blocks the write in its own cycle as well
    always_comb wr_allow = !locked_q && !lock_req;
endmodule

// File: rtl/auth_key_match.sv
// Decodes one keyed write register: offset match plus key match in the top byte.
// Assumes wr_en is already gated by the lock.
module auth_key_match #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int KEY_W  = 8,
    parameter int OFFSET = 0,
    parameter logic [KEY_W-1:0] KEY = '0
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              hit
);
    localparam int KEY_MSB = DATA_W - 1;

    // Offset and key must both match
    always_comb hit = wr_en && (addr == ADDR_W'(OFFSET)) && (wdata[KEY_MSB -: KEY_W] == KEY);
endmodule

// File: rtl/auth_setclr_reg.sv
// Authorization word updated only by write-one-to-set and write-one-to-clear strobes.
// Bits outside WR_MASK are constants at their reset value.
// Assumes set_stb and clr_stb are never high together.
module auth_setclr_reg #(
    parameter int WIDTH = 7,
    parameter logic [WIDTH-1:0] RST_VAL = '0,
    parameter logic [WIDTH-1:0] WR_MASK = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] q
);
    logic unused_fixed;
    always_comb unused_fixed = ^(bits & ~WR_MASK);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (WR_MASK[i]) begin : g_rw
            logic bit_q;
            // Apply a set or clear to this writable bit
            always_ff @(posedge clk) begin
                if (!rst_n)                  bit_q <= RST_VAL[i];
                else if (set_stb && bits[i]) bit_q <= 1'b1;
                else if (clr_stb && bits[i]) bit_q <= 1'b0;
            end
            assign q[i] = bit_q;
        end else begin : g_fixed
            assign q[i] = RST_VAL[i];
        end
    end
endmodule

// File: rtl/dbg_auth_regs.sv
// Top of the keyed debug-authorization registers: lock, key decode,
// the two authorization words and combinational read-back.
// Assumes one offset per write and read data taken the same cycle.
module dbg_auth_regs
    import dbg_auth_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              lock_req,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PORT_W-1:0] port_auth,
    output logic [CPU_W-1:0]  cpu_auth
);
    logic                   wr_allow;
    logic                   wr_gated;
    logic [NUM_WRITERS-1:0] hit;
    logic                   unused_mid;

    always_comb unused_mid = ^bus_wdata[DATA_W-KEY_W-1:PORT_W];

    auth_lock u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_req (lock_req),
        .wr_allow (wr_allow)
    );

    // Writes pass only while unlocked
    always_comb wr_gated = bus_wr && wr_allow;

    for (genvar g = 0; g < NUM_WRITERS; g++) begin : g_dec
        auth_key_match #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .KEY_W  (KEY_W),
            .OFFSET (WR_OFFSET[g]),
            .KEY    (WR_KEY[g])
        ) u_match (
            .wr_en (wr_gated),
            .addr  (bus_addr),
            .wdata (bus_wdata),
            .hit   (hit[g])
        );
    end

    auth_setclr_reg #(
        .WIDTH   (PORT_W),
        .RST_VAL (PORT_RST),
        .WR_MASK (PORT_MASK)
    ) u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (hit[WR_PORT_SET]),
        .clr_stb (hit[WR_PORT_CLR]),
        .bits    (bus_wdata[PORT_W-1:0]),
        .q       (port_auth)
    );

    auth_setclr_reg #(
        .WIDTH   (CPU_W),
        .RST_VAL (CPU_RST),
        .WR_MASK (CPU_MASK)
    ) u_cpu (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (hit[WR_CPU_SET]),
        .clr_stb (hit[WR_CPU_CLR]),
        .bits    (bus_wdata[CPU_W-1:0]),
        .q       (cpu_auth)
    );

    // Read-back: status words only; keyed registers and holes read zero
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFF_PORT_STAT))
            bus_rdata = {{(DATA_W-PORT_W){1'b0}}, port_auth};
        else if (bus_addr == ADDR_W'(OFF_CPU_STAT))
            bus_rdata = {{(DATA_W-CPU_W){1'b0}}, cpu_auth};
    end
endmodule

// File: rtl/dbg_auth_regs_chk.sv
// Property checker for dbg_auth_regs, attached by bind.
// Assumes single-offset writes and lock_req low during reset.
module dbg_auth_regs_chk
    import dbg_auth_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              lock_req,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PORT_W-1:0] port_auth,
    input logic [CPU_W-1:0]  cpu_auth
);
    localparam int KEY_MSB = DATA_W - 1;
    logic             seen_lock;
    logic [KEY_W-1:0] key;
    logic             key_known;

    // Independent record of a lock request since reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen_lock <= 1'b0;
        else        seen_lock <= seen_lock | lock_req;
    end

    // Classify the key on the bus
    always_comb begin
        key       = bus_wdata[KEY_MSB -: KEY_W];
        key_known = (key == WR_KEY[0]) || (key == WR_KEY[1]) ||
                    (key == WR_KEY[2]) || (key == WR_KEY[3]);
    end

    AST_PORT_SET_ONLY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(WR_OFFSET[0]) && key == WR_KEY[0]
        |=> (port_auth & $past(port_auth)) == $past(port_auth)); // R2
    AST_PORT_CLR_ONLY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(WR_OFFSET[1]) && key == WR_KEY[1]
        |=> (port_auth & ~$past(port_auth)) == '0); // R3
    AST_CPU_SET_ONLY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(WR_OFFSET[2]) && key == WR_KEY[2]
        |=> (cpu_auth & $past(cpu_auth)) == $past(cpu_auth)); // R4
    AST_CPU_CLR_ONLY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'(WR_OFFSET[3]) && key == WR_KEY[3]
        |=> (cpu_auth & ~$past(cpu_auth)) == '0); // R5
    AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !key_known |=> $stable(port_auth) && $stable(cpu_auth)); // R6
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(port_auth) && $stable(cpu_auth)); // R10
    AST_RESERVED_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        port_auth[1] && !port_auth[3]); // R7
    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_req || seen_lock) |=> $stable(port_auth) && $stable(cpu_auth)); // R8
    AST_KEYED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(WR_OFFSET[0]) || bus_addr == ADDR_W'(WR_OFFSET[1]) ||
         bus_addr == ADDR_W'(WR_OFFSET[2]) || bus_addr == ADDR_W'(WR_OFFSET[3]))
        |-> bus_rdata == '0); // R9
endmodule

bind dbg_auth_regs dbg_auth_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .lock_req  (lock_req),
    .bus_rdata (bus_rdata),
    .port_auth (port_auth),
    .cpu_auth  (cpu_auth)
);

// File: tb/dbg_auth_regs_test.sv
module dbg_auth_regs_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h200;
    logic [31:0] bus_wdata = '0;
    logic        lock_req = 1'b0;
    logic [31:0] bus_rdata;
    logic [6:0]  port_auth;
    logic [1:0]  cpu_auth;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    dbg_auth_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .lock_req  (lock_req),
        .bus_rdata (bus_rdata),
        .port_auth (port_auth),
        .cpu_auth  (cpu_auth)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Stimulus table: offset, data, expected port word, expected cpu word, requirement
    localparam logic [11:0] V_ADDR [NV] = '{12'h204, 12'h208, 12'h204, 12'h204, 12'h208,
        12'h204, 12'h214, 12'h218, 12'h218, 12'h214, 12'h204, 12'h218, 12'h300};
    localparam logic [31:0] V_DATA [NV] = '{32'hA5000064, 32'h22000011, 32'h5A0000FF,
        32'h220000FF, 32'h2200000A, 32'hA5000008, 32'h39000003, 32'h7D000001,
        32'h39000002, 32'hA5000001, 32'hA5FFFF11, 32'h7D000002, 32'hA5000075};
    localparam logic [6:0] V_PORT [NV] = '{7'h77, 7'h66, 7'h66, 7'h66, 7'h66, 7'h66,
        7'h66, 7'h66, 7'h66, 7'h66, 7'h77, 7'h77, 7'h77};
    localparam logic [1:0] V_CPU [NV] = '{2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd0,
        2'd3, 2'd2, 2'd2, 2'd2, 2'd2, 2'd0, 2'd0};
    // R2, R3, R6 bad key, R6 foreign key, R7, R7, R4, R5, R6, R6, R2 mid bits, R5, R6 hole
    localparam int V_REQ [NV] = '{2, 3, 6, 6, 7, 7, 4, 5, 6, 6, 2, 5, 6};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic write(input logic [11:0] a, input logic [31:0] d, input logic lk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; lock_req = lk;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 12'h200; bus_wdata = '0;
    endtask

    task automatic check_words(input string req, input logic [6:0] ep, input logic [1:0] ec);
        bus_addr = 12'h200; #1;
        check(req, {25'd0, port_auth}, {25'd0, ep});
        check(req, bus_rdata, {25'd0, ep});
        bus_addr = 12'h210; #1;
        check(req, {30'd0, cpu_auth}, {30'd0, ec});
        check(req, bus_rdata, {30'd0, ec});
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; lock_req = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_words("R1", 7'h13, 2'd0);

        for (int i = 0; i < NV; i++) begin
            write(V_ADDR[i], V_DATA[i], 1'b0);
            check_words($sformatf("R%0d", V_REQ[i]), V_PORT[i], V_CPU[i]);
        end

        // R9: keyed and unmapped offsets read zero
        for (int k = 0; k < 5; k++) begin
            bus_addr = (k == 4) ? 12'h300 : ((k < 2) ? 12'h204 + 12'(k*4) : 12'h214 + 12'((k-2)*4));
            #1 check("R9", bus_rdata, 32'd0);
        end

        // R8: a write in the request cycle is blocked, later writes too
        write(12'h208, 32'h22000040, 1'b1);
        lock_req = 1'b0;
        check_words("R8", 7'h77, 2'd0);
        write(12'h208, 32'h22000075, 1'b0);
        write(12'h214, 32'h39000003, 1'b0);
        check_words("R8", 7'h77, 2'd0);

        // R1: reset restores defaults and releases the lock
        do_reset();
        check_words("R1", 7'h13, 2'd0);
        write(12'h214, 32'h39000001, 1'b0);
        check_words("R10", 7'h13, 2'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule